// File: doc/BRIEF.md
# Expansion Bus Cycle Sequencer

This block is the host side of a PC-style 8/16-bit expansion bus. A client places one transfer on a simple request port. The request carries an address, a direction, a memory or I/O select, a width and the write data. The sequencer then plays out the bus cycle, clock by clock. It pulses the address latch strobe, holds the system address and the latchable upper address, drives byte-high enable for wide attempts, and lowers exactly one of the four active-low command strobes.

The length of the command phase starts from a wait count that depends on the transfer width. The target can shorten it with the no-wait-state input or stretch it by holding channel-ready low. On a wide request the target must report 16-bit capability: memory targets through the memory-width select and I/O targets through the I/O-width select. If the target does not report it, the sequencer finishes the current transfer as a byte and adds a second byte transfer at the odd address. When the last transfer ends, a one-clock done pulse presents the assembled read data. New requests are taken only while the block is idle.

The bus clock is the block clock. Address-enable is held low because every cycle this block makes is a normal, non-DMA cycle.

Top module: `xbus_cycle_seq`

## Requirements
- R1: Each transfer begins with exactly one clock of `ale_o` high with all command strobes high. `sa_o` and `la_o` (request address bits 23..17) stay unchanged through every command clock of that transfer.
- R2: `aen_o` is always low. While a transfer is in progress exactly one strobe is low, chosen as follows: I/O read `ior_no`, I/O write `iow_no`, memory read `memr_no`, memory write `memw_no`. All strobes are high otherwise.
- R3: With no-wait-state high and channel-ready high, a byte transfer keeps its strobe low for 5 clocks (1 + 4 waits) and a 16-bit transfer for 2 clocks (1 + 1 wait). Done comes one clock after the last command clock.
- R4: No-wait-state sampled low at the end of a command clock ends the transfer at that edge. This applies to byte transfers and 16-bit memory transfers. It is ignored on 16-bit I/O transfers.
- R5: Channel-ready low at the end of a command clock prevents the transfer from ending there. In a wait clock it also freezes the wait count, so each such clock adds one clock. It overrides no-wait-state.
- R6: A wide request drives `sbhe_no` low and clears address bit 0 for its first transfer. Memory width is taken from `mem16_ni`, sampled at the end of the latch clock and again at the end of the first command clock; either low sample counts. I/O width is taken from `io16_ni` at the end of the first command clock. A memory cycle ignores `io16_ni` and an I/O cycle ignores `mem16_ni`.
- R7: An unacknowledged wide request completes its first transfer with byte waits. It then runs a second transfer at address bit 0 = 1 with `sbhe_no` high. Both bytes use data lane 7..0.
- R8: Read data is captured at the edge ending the last command clock. A 16-bit transfer takes `sd_i[15:0]`. A split request takes `sd_i[7:0]` into bits 7..0 from the first transfer and into bits 15..8 from the second. A byte request returns {8'h00, `sd_i[7:0]`}. Writes return 0.
- R9: On writes `sd_oe_o` is high in every command clock and low otherwise. `sd_o` carries the full word, except in the second split transfer, where bits 7..0 carry write bits 15..8. On reads `sd_oe_o` stays low.
- R10: `done_o` is a single-clock pulse that coincides with `ready_o` high. `req_i` pulses while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block and bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken when idle |
| req_we_i | input | 1 | 1 = write |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_wide_i | input | 1 | 1 = 16-bit request |
| req_addr_i | input | 24 | Request address |
| req_wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Idle, request may be issued |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data, valid with done |
| ale_o | output | 1 | Address latch strobe |
| aen_o | output | 1 | Address enable (held low) |
| sa_o | output | 20 | System address |
| la_o | output | 7 | Latchable upper address |
| sbhe_no | output | 1 | Byte-high enable, active low |
| ior_no | output | 1 | I/O read strobe |
| iow_no | output | 1 | I/O write strobe |
| memr_no | output | 1 | Memory read strobe |
| memw_no | output | 1 | Memory write strobe |
| io16_ni | input | 1 | Target I/O 16-bit select |
| mem16_ni | input | 1 | Target memory 16-bit select |
| nows_ni | input | 1 | No-wait-state request |
| chrdy_i | input | 1 | Channel ready, low inserts waits |
| sd_o | output | 16 | Data bus drive value |
| sd_oe_o | output | 1 | Data bus drive enable |
| sd_i | input | 16 | Data bus sampled value |

## Verification
No-wait-state and channel-ready can both be low in the same command clock. One directed case holds both low across the first command clock and two waits. It expects the transfer to run exactly until channel-ready returns, and not to stop at the first no-wait sample. The other collision is the width decision against no-wait-state on the very first command clock. The bench lowers no-wait-state for 16-bit memory, 16-bit I/O and unacknowledged wide requests. It judges each case by the measured strobe-low length per transfer and by the number of transfers.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ALE, ST_CMD, ST_WAIT} seq_st_e;
endpackage

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
  parameter int WAIT8  = 4,
  parameter int WAIT16 = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic narrow_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int WMAX = (WAIT8 > WAIT16) ? WAIT8 : WAIT16;
  localparam int CW   = $clog2(WMAX + 1);
  localparam logic [CW-1:0] LD8  = CW'(WAIT8);
  localparam logic [CW-1:0] LD16 = CW'(WAIT16);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= narrow_i ? LD8 : LD16;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CW'(1));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(WMAX)) else $error("wait count out of range");
  p_load_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == LD8 || cnt_q == LD16)) else $error("bad wait load");
endmodule

// File: rtl/xbus_width_sense.sv
module xbus_width_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ale_i,
  input  logic io_i,
  input  logic io16_ni,
  input  logic mem16_ni,
  output logic ack16_o
);
  logic mem_early_q;

  // first memory-width sample at the end of the latch clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mem_early_q <= 1'b0;
    else if (ale_i) mem_early_q <= !mem16_ni;
  end

  // second sample is live; each space ignores the other space's select
  assign ack16_o = io_i ? !io16_ni : (mem_early_q | !mem16_ni);
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen (
  input  logic active_i,
  input  logic io_i,
  input  logic we_i,
  output logic ior_no,
  output logic iow_no,
  output logic memr_no,
  output logic memw_no
);
  always_comb begin
    ior_no  = !(active_i &  io_i & !we_i);
    iow_no  = !(active_i &  io_i &  we_i);
    memr_no = !(active_i & !io_i & !we_i);
    memw_no = !(active_i & !io_i &  we_i);
  end
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_seq_pkg::*;
#(
  parameter int AW     = 24,
  parameter int SAW    = 20,
  parameter int LA_LO  = 17,
  parameter int DW     = 16,
  parameter int WAIT8  = 4,
  parameter int WAIT16 = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_io_i,
  input  logic              req_wide_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic              ale_o,
  output logic              aen_o,
  output logic [SAW-1:0]    sa_o,
  output logic [AW-LA_LO-1:0] la_o,
  output logic              sbhe_no,
  output logic              ior_no,
  output logic              iow_no,
  output logic              memr_no,
  output logic              memw_no,
  input  logic              io16_ni,
  input  logic              mem16_ni,
  input  logic              nows_ni,
  input  logic              chrdy_i,
  output logic [DW-1:0]     sd_o,
  output logic              sd_oe_o,
  input  logic [DW-1:0]     sd_i
);
  localparam int BW    = DW / 2;
  localparam int LANES = 2;

  seq_st_e       st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q, io_q, wide_q, second_q, x16_q, done_q;
  logic [BW-1:0] lane_q [LANES];

  logic in_ale, in_cmd, in_wait, cmd_on, accept;
  logic ack16, wt_last, x16_cur, nows_hit, xfer_end, split_next;

  assign in_ale  = (st_q == ST_ALE);
  assign in_cmd  = (st_q == ST_CMD);
  assign in_wait = (st_q == ST_WAIT);
  assign cmd_on  = in_cmd | in_wait;
  assign accept  = (st_q == ST_IDLE) & req_i;

  xbus_width_sense u_width (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ale_i    (in_ale),
    .io_i     (io_q),
    .io16_ni  (io16_ni),
    .mem16_ni (mem16_ni),
    .ack16_o  (ack16)
  );

  // width is settled at the end of the first command clock
  assign x16_cur    = in_cmd ? (x16_q & ack16) : x16_q;
  assign nows_hit   = !nows_ni & !(x16_cur & io_q);
  assign xfer_end   = cmd_on & chrdy_i & (nows_hit | (in_wait & wt_last));
  assign split_next = wide_q & !second_q & !x16_cur;

  xbus_wait_timer #(.WAIT8(WAIT8), .WAIT16(WAIT16)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (in_cmd & !xfer_end),
    .narrow_i (!x16_cur),
    .dec_i    (in_wait & chrdy_i & !xfer_end),
    .last_o   (wt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      io_q     <= 1'b0;
      wide_q   <= 1'b0;
      second_q <= 1'b0;
      x16_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          addr_q   <= req_addr_i;
          wdata_q  <= req_wdata_i;
          we_q     <= req_we_i;
          io_q     <= req_io_i;
          wide_q   <= req_wide_i;
          x16_q    <= req_wide_i;
          second_q <= 1'b0;
          st_q     <= ST_ALE;
        end
        ST_ALE: st_q <= ST_CMD;
        default: begin
          if (in_cmd) x16_q <= x16_cur;
          if (xfer_end) begin
            if (split_next) begin
              second_q <= 1'b1;
              x16_q    <= 1'b0;
              st_q     <= ST_ALE;
            end else begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end else begin
            st_q <= ST_WAIT;
          end
        end
      endcase
    end
  end

  // read lanes: lane 0 from low byte unless second half; lane 1 from high
  // byte on a wide transfer or from the low byte in the second half
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          lane_we;
    logic [BW-1:0] lane_src;
    if (g == 0) begin : g_lo
      assign lane_we  = !second_q;
      assign lane_src = sd_i[BW-1:0];
    end else begin : g_hi
      assign lane_we  = second_q | x16_cur;
      assign lane_src = second_q ? sd_i[BW-1:0] : sd_i[DW-1:BW];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          lane_q[g] <= '0;
      else if (accept)                      lane_q[g] <= '0;
      else if (xfer_end && lane_we && !we_q) lane_q[g] <= lane_src;
    end
  end

  xbus_strobe_gen u_strobe (
    .active_i (cmd_on),
    .io_i     (io_q),
    .we_i     (we_q),
    .ior_no   (ior_no),
    .iow_no   (iow_no),
    .memr_no  (memr_no),
    .memw_no  (memw_no)
  );

  assign ready_o = (st_q == ST_IDLE);
  assign done_o  = done_q;
  assign rdata_o = {lane_q[1], lane_q[0]};
  assign ale_o   = in_ale;
  assign aen_o   = 1'b0;
  assign sa_o    = {addr_q[SAW-1:1], wide_q ? second_q : addr_q[0]};
  assign la_o    = addr_q[AW-1:LA_LO];
  assign sbhe_no = !(wide_q & !second_q & (st_q != ST_IDLE));
  assign sd_oe_o = we_q & cmd_on;
  assign sd_o    = second_q ? {{BW{1'b0}}, wdata_q[DW-1:BW]} : wdata_q;

  logic [3:0] strb_n;
  assign strb_n = {ior_no, iow_no, memr_no, memw_no};

  p_ale_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o) else $error("latch strobe longer than one clock");
  p_no_cmd_in_ale_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (strb_n == 4'hF)) else $error("strobe during latch clock");
  p_sa_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_on && $past(cmd_on)) |-> ($stable(sa_o) && $stable(la_o)))
    else $error("address moved in command phase");
  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~strb_n) <= 1) else $error("more than one strobe low");
  p_chrdy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_on && !chrdy_i) |=> (strb_n != 4'hF)) else $error("ended while not ready");
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done wider than one clock");
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o) else $error("done while busy");
  p_oe_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_n != 4'hF && (!ior_no || !memr_no)) |-> !sd_oe_o) else $error("drive on read");
endmodule

// File: tb/test_xbus_cycle_seq.sv
module test_xbus_cycle_seq;
  localparam int W8 = 4, W16 = 1;

  typedef struct packed {
    logic        io;
    logic        we;
    logic        wide;
    logic [1:0]  ack;   // 0 none, 1 early, 2 late (mem) , 3 wrong-space select only
    logic        nows;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic [3:0]  exp_nx;
    logic [7:0]  exp_clk;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0,1'b0,1'b0,2'd0,1'b0,24'h012345,16'h0000,4'd1,8'd7},
    '{1'b1,1'b1,1'b0,2'd0,1'b0,24'h000301,16'h00A7,4'd1,8'd7},
    '{1'b0,1'b0,1'b1,2'd1,1'b0,24'hABCDE4,16'h0000,4'd1,8'd4},
    '{1'b0,1'b1,1'b1,2'd2,1'b0,24'h0C0010,16'h1234,4'd1,8'd4},
    '{1'b1,1'b0,1'b1,2'd1,1'b0,24'h000220,16'h0000,4'd1,8'd4},
    '{1'b0,1'b0,1'b1,2'd0,1'b0,24'h000457,16'h0000,4'd2,8'd13},
    '{1'b1,1'b1,1'b1,2'd0,1'b0,24'h000310,16'hBEEF,4'd2,8'd13},
    '{1'b0,1'b0,1'b1,2'd3,1'b0,24'h3A0082,16'h0000,4'd2,8'd13},
    '{1'b1,1'b0,1'b1,2'd3,1'b0,24'h000240,16'h0000,4'd2,8'd13},
    '{1'b0,1'b0,1'b0,2'd0,1'b1,24'h0F00F1,16'h0000,4'd1,8'd3},
    '{1'b0,1'b0,1'b1,2'd1,1'b1,24'h123456,16'h0000,4'd1,8'd3},
    '{1'b1,1'b0,1'b1,2'd1,1'b1,24'h000360,16'h0000,4'd1,8'd4},
    '{1'b1,1'b1,1'b0,2'd0,1'b1,24'h000278,16'h005C,4'd1,8'd3},
    '{1'b0,1'b1,1'b1,2'd0,1'b1,24'h0A0A0A,16'hC3D2,4'd2,8'd5}
  };

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0, req_io = 0, req_wide = 0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic ready, done, ale, aen, sbhe_n, ior_n, iow_n, memr_n, memw_n, sd_oe;
  logic [15:0] rdata, sd_out;
  logic [19:0] sa;
  logic [6:0] la;
  logic io16_n = 1, mem16_n = 1, nows_n = 1, chrdy = 1;
  logic [15:0] sd_in = 16'hFFFF;

  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  xbus_cycle_seq i_xbus_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we), .req_io_i(req_io),
    .req_wide_i(req_wide), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .ale_o(ale), .aen_o(aen),
    .sa_o(sa), .la_o(la), .sbhe_no(sbhe_n), .ior_no(ior_n), .iow_no(iow_n),
    .memr_no(memr_n), .memw_no(memw_n), .io16_ni(io16_n), .mem16_ni(mem16_n),
    .nows_ni(nows_n), .chrdy_i(chrdy), .sd_o(sd_out), .sd_oe_o(sd_oe), .sd_i(sd_in)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [19:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  function automatic int xlen(input bit w16, input bit io, input bit nw);
    if (nw && !(w16 && io)) return 1;
    return w16 ? 1 + W16 : 1 + W8;
  endfunction

  task automatic run_req(input vec_t v, input int cs, input int cl, input string tag);
    int nx = 0, clocks = 0, cidx = 0, ale_cnt = 0, idx;
    int len [2];
    logic [19:0] sar [2];
    logic [6:0]  lar [2];
    logic        sbr [2];
    logic [15:0] sdr [2];
    bit strobe_bad = 0, sa_moved = 0, aen_bad = 0, oe_bad = 0, cmd_on, act;
    bit acked = v.wide && (v.ack == 2'd1 || v.ack == 2'd2);
    logic [3:0] cmd_n, pat;
    logic [19:0] a0;
    logic [15:0] exp_rd, rd;
    len[0] = 0; len[1] = 0; sdr[0] = '0; sdr[1] = '0;
    sar[0] = '0; sar[1] = '0; lar[0] = '0; lar[1] = '0; sbr[0] = 1; sbr[1] = 1;
    pat = v.io ? (v.we ? 4'b1011 : 4'b0111) : (v.we ? 4'b1110 : 4'b1101);
    @(negedge clk);
    req_we = v.we; req_io = v.io; req_wide = v.wide; req_addr = v.addr;
    req_wdata = v.wdata; nows_n = !v.nows; req = 1;
    @(negedge clk);
    req = 0;
    forever begin
      clocks++;
      cmd_n = {ior_n, iow_n, memr_n, memw_n};
      cmd_on = (cmd_n != 4'hF);
      if (aen) aen_bad = 1;
      if (ale) begin
        if (nx < 2) begin sar[nx] = sa; lar[nx] = la; sbr[nx] = sbhe_n; end
        nx++; ale_cnt++; cidx = 0;
        if (cmd_on) strobe_bad = 1;
      end else if (cmd_on) begin
        cidx++;
        idx = (nx > 0 && nx <= 2) ? nx - 1 : 1;
        len[idx]++;
        if (cmd_n != pat) strobe_bad = 1;
        if (sa != sar[idx] || la != lar[idx]) sa_moved = 1;
        if (sd_oe !== v.we) oe_bad = 1;
        if (sd_oe) sdr[idx] = sd_out;
      end else if (sd_oe) oe_bad = 1;
      if (done || clocks > 300) break;
      act = ale || cmd_on;
      io16_n = 1; mem16_n = 1;
      if (act) begin
        if (v.io) begin
          if (v.ack == 2'd1 || v.ack == 2'd2) io16_n = 0;
          else if (v.ack == 2'd3) mem16_n = 0;
        end else begin
          if (v.ack == 2'd1) mem16_n = 0;
          else if (v.ack == 2'd2 && cmd_on) mem16_n = 0;
          else if (v.ack == 2'd3) io16_n = 0;
        end
      end
      chrdy = !(cmd_on && cidx >= cs && cidx < cs + cl);
      sd_in = cmd_on ? {(acked && !sbhe_n) ? byte_at(sa | 20'h1) : 8'hEE, byte_at(sa)}
                     : 16'hFFFF;
      @(negedge clk);
    end
    rd = rdata;
    io16_n = 1; mem16_n = 1; chrdy = 1; nows_n = 1; sd_in = 16'hFFFF;

    a0 = v.addr[19:0];
    chk(nx == int'(v.exp_nx), {tag, " R7 transfer count"}, nx, v.exp_nx);
    chk(clocks == int'(v.exp_clk) + (cl > 0 ? 0 : 0),
        {tag, (cl > 0) ? " R5 clocks" : (v.nows ? " R4 clocks" : " R3 clocks")}, clocks, v.exp_clk);
    chk(ale_cnt == nx, {tag, " R1 latch pulses"}, ale_cnt, nx);
    chk(!sa_moved, {tag, " R1 address stable"}, sa_moved, 0);
    chk(lar[0] == v.addr[23:17], {tag, " R1 upper address"}, lar[0], v.addr[23:17]);
    chk(!strobe_bad && !aen_bad, {tag, " R2 strobe/aen"}, {strobe_bad, aen_bad}, 0);
    if (cl == 0) begin
      if (v.wide && acked)
        chk(len[0] == xlen(1, v.io, v.nows), {tag, " R4 wide length"}, len[0], xlen(1, v.io, v.nows));
      else
        chk(len[0] == xlen(0, v.io, v.nows), {tag, " R3 byte length"}, len[0], xlen(0, v.io, v.nows));
    end
    if (v.wide) begin
      chk(sar[0] == {a0[19:1], 1'b0} && sbr[0] == 1'b0, {tag, " R6 first sa/sbhe"},
          {sbr[0], sar[0]}, {1'b0, a0[19:1], 1'b0});
      if (!acked) begin
        chk(sar[1] == {a0[19:1], 1'b1} && sbr[1] == 1'b1, {tag, " R7 second sa/sbhe"},
            {sbr[1], sar[1]}, {1'b1, a0[19:1], 1'b1});
        chk(len[1] == xlen(0, v.io, v.nows), {tag, " R7 second length"}, len[1], xlen(0, v.io, v.nows));
      end
    end else begin
      chk(sar[0] == a0 && sbr[0] == 1'b1, {tag, " R6 byte sa/sbhe"}, {sbr[0], sar[0]}, {1'b1, a0});
    end
    if (v.we) exp_rd = 16'h0;
    else if (v.wide) exp_rd = {byte_at({a0[19:1], 1'b1}), byte_at({a0[19:1], 1'b0})};
    else exp_rd = {8'h00, byte_at(a0)};
    chk(rd == exp_rd, {tag, " R8 read data"}, rd, exp_rd);
    if (v.we) begin
      chk(sdr[0][7:0] == v.wdata[7:0], {tag, " R9 write low lane"}, sdr[0][7:0], v.wdata[7:0]);
      if (v.wide && acked)
        chk(sdr[0] == v.wdata, {tag, " R9 write word"}, sdr[0], v.wdata);
      if (v.wide && !acked)
        chk(sdr[1][7:0] == v.wdata[15:8], {tag, " R9 write second byte"}, sdr[1][7:0], v.wdata[15:8]);
    end
    chk(!oe_bad, {tag, " R9 drive enable"}, oe_bad, 0);
    chk(ready, {tag, " R10 ready with done"}, ready, 1);
    @(negedge clk);
    chk(!done && ready, {tag, " R10 done single pulse"}, {done, ready}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk(ready && !done && !ale && !aen, "R10 reset state", {ready, done, ale, aen}, 4'b1000);
    chk({ior_n, iow_n, memr_n, memw_n, sbhe_n} == 5'h1F && !sd_oe, "R2 reset strobes",
        {ior_n, iow_n, memr_n, memw_n, sbhe_n, sd_oe}, 6'b111110);
    rst_n = 1;
    @(negedge clk);
    chk(ready && !ale && {ior_n, iow_n, memr_n, memw_n} == 4'hF, "R2 idle after reset",
        {ready, ale}, 2'b10);

    foreach (VECS[i]) run_req(VECS[i], 0, 0, $sformatf("vec%0d", i));

    // channel-ready low for three wait clocks on a byte read
    d = '{1'b0,1'b0,1'b0,2'd0,1'b0,24'h004422,16'h0,4'd1,8'd10};
    run_req(d, 2, 3, "chrdy_stretch");
    // channel-ready low with no-wait-state low from the first command clock
    d = '{1'b0,1'b0,1'b0,2'd0,1'b1,24'h004423,16'h0,4'd1,8'd6};
    run_req(d, 1, 3, "chrdy_over_nows");

    // request pulse while busy is ignored (R10)
    d = '{1'b1,1'b0,1'b0,2'd0,1'b0,24'h000388,16'h0,4'd1,8'd7};
    fork
      run_req(d, 0, 0, "busy_req");
      begin
        repeat (4) @(negedge clk);
        req_addr = 24'h0000FF; req = 1;
        @(negedge clk);
        req = 0;
      end
    join
    begin
      bit saw_ale = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (ale || !ready) saw_ale = 1;
      end
      chk(!saw_ale, "R10 busy request ignored", saw_ale, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule